// File: doc/BRIEF.md
# Data Memory with Indirect Access

This block is the data-memory side of a small 8-bit controller core. It decodes an 8-bit byte address, holds the general-purpose RAM and a pair of address pointers, and sends every other special-register address out through an external register port, where the timers, PWM, converter and I/O registers live. Low even addresses are pseudo-registers: an access to one of them is carried out at the address held in the pointer that sits one address above it.

Every access resolves in a single cycle. Read data is combinational from the address. Writes, and single-bit set or clear operations, commit at the next rising clock edge. A bit operation is a read-modify-write: the current byte is read, one bit picked by a 3-bit index is forced, and the result is written back in that same cycle. Reserved holes in the special range read as zero and take no writes. Read-only special registers never receive a write strobe.

Top module: `dmem_core`

## Requirements
- R1: Addresses 40H to FFH are 192 bytes of RAM. A byte written with `we_i` reads back unchanged on any later cycle, and RAM accesses raise no external strobe.
- R2: Address 00H is redirected to the address held in the first pointer, which is read and written at 01H. After reset the pointer holds 00H.
- R3: Address 02H is redirected to the address held in the second pointer, which is read and written at 03H. After reset this pointer also holds 00H.
- R4: An indirect access whose pointer holds 00H or 02H reads 00H. A write or bit operation through it changes nothing and raises no external strobe.
- R5: Addresses 04H to 3FH that are marked reserved (by default 04H, 09H, 0CH, 0FH and 26H to 3FH) read 00H, ignore writes and raise no external strobe.
- R6: Every other address from 04H to 3FH is forwarded on the external port. `ext_addr_o` carries the resolved address, `ext_re_o` is high when `re_i` or a bit operation is present, `ext_we_o` is high when a write or bit operation is present, and `rdata_o` returns `ext_rdata_i`.
- R7: A special address marked read-only (by default 20H and 21H) never raises `ext_we_o`, whether the access is a write or a bit operation.
- R8: `bit_set_i` sets the bit numbered `bit_idx_i` (0 is the least significant bit) of the resolved byte and leaves the other seven bits as they were. This works for RAM, the pointers and external registers, and the write takes one cycle.
- R9: `bit_clr_i` clears the selected bit. If both bit controls are high, the clear wins. A bit operation takes priority over `we_i`, so `wdata_i` is not used in that cycle.
- R10: `rdata_o` shows the resolved byte for the current address in the same cycle, with no register on the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| re_i | input | 1 | Read strobe; used only to qualify the external read strobe |
| we_i | input | 1 | Byte write enable |
| wdata_i | input | 8 | Write data |
| bit_set_i | input | 1 | Set the selected bit |
| bit_clr_i | input | 1 | Clear the selected bit |
| bit_idx_i | input | 3 | Bit index for set or clear |
| rdata_o | output | 8 | Read data for the resolved address |
| ext_addr_o | output | 8 | Resolved address sent to the external registers |
| ext_re_o | output | 1 | External read strobe |
| ext_we_o | output | 1 | External write strobe |
| ext_wdata_o | output | 8 | External write data, including the result of a bit operation |
| ext_rdata_i | input | 8 | External read data |

## Verification
On every cycle the assertions check four things: a null indirect access reads zero and stays silent, a reserved direct address reads zero, a write strobe never reaches a read-only register, and external strobes appear only for special-range addresses. Over one-cycle windows they also check that a RAM write or a RAM bit operation is visible on the next read of the same address, and that a write to the first pointer lands. The bench's scenarios cover the rest: redirection through each pointer, a write through a null pointer leaving the real location untouched, the value carried on the external port during a bit operation, and the priority of clear over set and of bit operations over byte writes.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    CLS_RAM,
    CLS_PTR,
    CLS_EXT,
    CLS_RSV,
    CLS_NULL
  } dmem_cls_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int                W        = 8,
  parameter int                RAM_BASE = 64,
  parameter int                NUM_PTR  = 2,
  parameter int                PSEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  parameter logic [RAM_BASE-1:0] RSV_MAP = '0,
  parameter logic [RAM_BASE-1:0] RO_MAP  = '0
) (
  input  logic [W-1:0]         addr_i,
  input  logic [NUM_PTR*W-1:0] ptr_i,
  output logic [W-1:0]         eff_o,
  output dmem_cls_e            cls_o,
  output logic [PSEL_W-1:0]    psel_o,
  output logic                 ro_o
);
  localparam int          MAP_AW  = $clog2(RAM_BASE);
  localparam logic [W-1:0] RAM_LO  = W'(RAM_BASE);
  localparam logic [W-1:0] PTR_END = W'(2 * NUM_PTR);

  // even address 2i redirects through pointer i (stored at 2i+1)
  always_comb begin
    eff_o = addr_i;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (addr_i == W'(2 * i)) eff_o = ptr_i[i*W +: W];
    end
  end

  assign psel_o = eff_o[1 +: PSEL_W];
  assign ro_o   = RO_MAP[eff_o[MAP_AW-1:0]];

  always_comb begin
    if (eff_o >= RAM_LO)                  cls_o = CLS_RAM;
    else if (eff_o < PTR_END)             cls_o = eff_o[0] ? CLS_PTR : CLS_NULL;
    else if (RSV_MAP[eff_o[MAP_AW-1:0]])  cls_o = CLS_RSV;
    else                                  cls_o = CLS_EXT;
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int W        = 8,
  parameter int RAM_BASE = 64
) (
  input  logic         clk_i,
  input  logic [W-1:0] eff_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  localparam int          DEPTH  = (1 << W) - RAM_BASE;
  localparam logic [W-1:0] RAM_LO = W'(RAM_BASE);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] idx;

  assign idx     = eff_i - RAM_LO;
  assign rdata_o = mem[idx];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx] <= wdata_i;
  end
endmodule

// File: rtl/dmem_ptr.sv
module dmem_ptr #(
  parameter int W       = 8,
  parameter int NUM_PTR = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PTR-1:0]   we_i,
  input  logic [W-1:0]         wdata_i,
  output logic [NUM_PTR*W-1:0] ptr_o
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (we_i[g]) q <= wdata_i;
    end
    assign ptr_o[g*W +: W] = q;
  end
endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int                W        = 8,
  parameter int                RAM_BASE = 64,
  parameter int                NUM_PTR  = 2,
  parameter int                IDX_W    = $clog2(W),
  parameter logic [RAM_BASE-1:0] RSV_MAP = 64'hFFFF_FFC0_0000_9210,
  parameter logic [RAM_BASE-1:0] RO_MAP  = 64'h0000_0003_0000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     addr_i,
  input  logic             re_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             bit_set_i,
  input  logic             bit_clr_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     ext_addr_o,
  output logic             ext_re_o,
  output logic             ext_we_o,
  output logic [W-1:0]     ext_wdata_o,
  input  logic [W-1:0]     ext_rdata_i
);
  localparam int PSEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  logic [NUM_PTR*W-1:0] ptr_flat;
  logic [W-1:0]         eff;
  dmem_cls_e            cls;
  logic [PSEL_W-1:0]    psel;
  logic                 ro;
  logic [W-1:0]         ram_rd, cur, mask, nxt;
  logic                 do_clr, do_set, do_bit, do_wr, ram_we;
  logic [NUM_PTR-1:0]   ptr_we;

  dmem_decode #(
    .W(W), .RAM_BASE(RAM_BASE), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W),
    .RSV_MAP(RSV_MAP), .RO_MAP(RO_MAP)
  ) u_dec (
    .addr_i (addr_i),
    .ptr_i  (ptr_flat),
    .eff_o  (eff),
    .cls_o  (cls),
    .psel_o (psel),
    .ro_o   (ro)
  );

  // clear beats set, bit ops beat byte writes
  assign do_clr = bit_clr_i;
  assign do_set = bit_set_i & ~bit_clr_i;
  assign do_bit = do_clr | do_set;
  assign do_wr  = do_bit | we_i;

  always_comb begin
    case (cls)
      CLS_RAM: cur = ram_rd;
      CLS_PTR: cur = ptr_flat[psel*W +: W];
      CLS_EXT: cur = ext_rdata_i;
      default: cur = '0;
    endcase
  end

  assign mask = W'(1) << bit_idx_i;
  always_comb begin
    if (do_clr)      nxt = cur & ~mask;
    else if (do_set) nxt = cur | mask;
    else             nxt = wdata_i;
  end

  assign ram_we = do_wr & (cls == CLS_RAM);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pwe
    assign ptr_we[g] = do_wr & (cls == CLS_PTR) & (psel == PSEL_W'(g));
  end

  dmem_ram #(.W(W), .RAM_BASE(RAM_BASE)) u_ram (
    .clk_i   (clk_i),
    .eff_i   (eff),
    .we_i    (ram_we),
    .wdata_i (nxt),
    .rdata_o (ram_rd)
  );

  dmem_ptr #(.W(W), .NUM_PTR(NUM_PTR)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ptr_we),
    .wdata_i (nxt),
    .ptr_o   (ptr_flat)
  );

  assign rdata_o     = cur;
  assign ext_addr_o  = eff;
  assign ext_wdata_o = nxt;
  assign ext_re_o    = (re_i | do_bit) & (cls == CLS_EXT);
  assign ext_we_o    = do_wr & (cls == CLS_EXT) & ~ro;
endmodule

// File: rtl/dmem_core_chk.sv
module dmem_core_chk #(
  parameter int                W        = 8,
  parameter int                RAM_BASE = 64,
  parameter int                NUM_PTR  = 2,
  parameter int                IDX_W    = 3,
  parameter logic [RAM_BASE-1:0] RSV_MAP = '0,
  parameter logic [RAM_BASE-1:0] RO_MAP  = '0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [W-1:0]         addr_i,
  input logic                 we_i,
  input logic [W-1:0]         wdata_i,
  input logic                 bit_set_i,
  input logic                 bit_clr_i,
  input logic [IDX_W-1:0]     bit_idx_i,
  input logic [W-1:0]         rdata_o,
  input logic [W-1:0]         ext_addr_o,
  input logic                 ext_re_o,
  input logic                 ext_we_o,
  input logic [NUM_PTR*W-1:0] ptr_flat
);
  localparam int          MAP_AW  = $clog2(RAM_BASE);
  localparam logic [W-1:0] RAM_LO  = W'(RAM_BASE);
  localparam logic [W-1:0] PTR_END = W'(2 * NUM_PTR);

  logic [W-1:0] p0;
  logic         any_bit, in_ram, rsv_direct;
  assign p0         = ptr_flat[W-1:0];
  assign any_bit    = bit_set_i | bit_clr_i;
  assign in_ram     = addr_i >= RAM_LO;
  assign rsv_direct = (addr_i >= PTR_END) && (addr_i < RAM_LO) && RSV_MAP[addr_i[MAP_AW-1:0]];

  assert_null_ind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0 && (p0 == W'(0) || p0 == W'(2))) |-> (rdata_o == '0 && !ext_re_o && !ext_we_o));

  assert_rsv_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_direct |-> (rdata_o == '0 && !ext_re_o && !ext_we_o));

  assert_ro_no_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> !RO_MAP[ext_addr_o[MAP_AW-1:0]]);

  assert_ext_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_re_o || ext_we_o) |-> (ext_addr_o >= PTR_END && ext_addr_o < RAM_LO
                                && !RSV_MAP[ext_addr_o[MAP_AW-1:0]]));

  assert_ram_wr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !any_bit && in_ram) ##1 (addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i));

  assert_bit_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_set_i && !bit_clr_i && in_ram) ##1 (addr_i == $past(addr_i))
      |-> rdata_o[$past(bit_idx_i)] == 1'b1);

  assert_bit_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_clr_i && in_ram) ##1 (addr_i == $past(addr_i)) |-> rdata_o[$past(bit_idx_i)] == 1'b0);

  assert_ptr_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !any_bit && addr_i == W'(1)) |=> p0 == $past(wdata_i));
endmodule

bind dmem_core dmem_core_chk #(
  .W(W), .RAM_BASE(RAM_BASE), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W),
  .RSV_MAP(RSV_MAP), .RO_MAP(RO_MAP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .bit_set_i  (bit_set_i),
  .bit_clr_i  (bit_clr_i),
  .bit_idx_i  (bit_idx_i),
  .rdata_o    (rdata_o),
  .ext_addr_o (ext_addr_o),
  .ext_re_o   (ext_re_o),
  .ext_we_o   (ext_we_o),
  .ptr_flat   (ptr_flat)
);

// File: tb/dmem_core_test.sv
`timescale 1ns/1ps
module dmem_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       re = 1'b0, we = 1'b0, bset = 1'b0, bclr = 1'b0;
  logic [2:0] bidx = '0;
  logic [7:0] rdata, ext_addr, ext_wdata, ext_rdata;
  logic       ext_re, ext_we;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ext_mem [64];

  always #10 clk = ~clk;  // 50 MHz

  dmem_core uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .re_i(re), .we_i(we), .wdata_i(wdata),
    .bit_set_i(bset), .bit_clr_i(bclr), .bit_idx_i(bidx), .rdata_o(rdata),
    .ext_addr_o(ext_addr), .ext_re_o(ext_re), .ext_we_o(ext_we),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata)
  );

  assign ext_rdata = ext_mem[ext_addr[5:0]];
  always @(posedge clk) if (ext_we) ext_mem[ext_addr[5:0]] <= ext_wdata;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    re = 0; we = 0; bset = 0; bclr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); idle(); addr = a; wdata = d; we = 1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); idle(); addr = a; re = 1;
    #2 d = rdata;
  endtask

  task automatic bitop(input logic [7:0] a, input logic s, input logic c, input logic [2:0] i);
    @(negedge clk); idle(); addr = a; bset = s; bclr = c; bidx = i;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h01, v); check("R2 reset ptr0", v, 8'h00);
    rd(8'h03, v); check("R3 reset ptr1", v, 8'h00);
    rd(8'h00, v); check("R4 null via ptr0=00", v, 8'h00);
  endtask

  task automatic t_ram();
    logic [7:0] v;
    wr(8'h40, 8'h12); wr(8'hFF, 8'hED); wr(8'h7F, 8'h5A);
    rd(8'h40, v); check("R1 ram 40", v, 8'h12);
    rd(8'hFF, v); check("R1 ram FF", v, 8'hED);
    rd(8'h7F, v); check("R1 ram 7F", v, 8'h5A);
    check("R1 no ext strobe on ram", {6'b0, ext_re, ext_we}, 8'h00);
    @(negedge clk); idle(); addr = 8'h40; #2 check("R10 comb read", rdata, 8'h12);
  endtask

  task automatic t_ind0();
    logic [7:0] v;
    wr(8'h01, 8'h45); wr(8'h00, 8'hA5);
    rd(8'h45, v); check("R2 write via ptr0", v, 8'hA5);
    rd(8'h00, v); check("R2 read via ptr0", v, 8'hA5);
  endtask

  task automatic t_ind1();
    logic [7:0] v;
    wr(8'h03, 8'hFE); wr(8'h02, 8'hC3);
    rd(8'hFE, v); check("R3 write via ptr1", v, 8'hC3);
    rd(8'h03, v); check("R3 ptr1 value", v, 8'hFE);
  endtask

  task automatic t_null();
    logic [7:0] v;
    wr(8'h01, 8'h02);
    @(negedge clk); idle(); addr = 8'h00; wdata = 8'h11; we = 1;
    #2 check("R4 no ext we on null", {7'b0, ext_we}, 8'h00);
    @(negedge clk); idle();
    rd(8'h00, v); check("R4 null read", v, 8'h00);
    rd(8'h02, v); check("R4 target untouched", v, 8'hC3);
    rd(8'h01, v); check("R4 ptr0 kept", v, 8'h02);
    bitop(8'h00, 1, 0, 3'd0);
    rd(8'hFE, v); check("R4 bitop via null ignored", v, 8'hC3);
  endtask

  task automatic t_rsv();
    logic [7:0] v;
    @(negedge clk); idle(); addr = 8'h30; wdata = 8'h5A; we = 1;
    #2 check("R5 no ext we on reserved", {7'b0, ext_we}, 8'h00);
    @(negedge clk); idle();
    rd(8'h30, v); check("R5 reserved 30 reads 0", v, 8'h00);
    check("R5 no ext re on reserved", {7'b0, ext_re}, 8'h00);
    rd(8'h04, v); check("R5 reserved 04 reads 0", v, 8'h00);
    check("R5 reserved 30 untouched in ext", ext_mem[6'h30], 8'h99);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    rd(8'h10, v);
    check("R6 ext read data", v, 8'h3C);
    check("R6 ext re", {7'b0, ext_re}, 8'h01);
    check("R6 ext addr", ext_addr, 8'h10);
    @(negedge clk); idle(); addr = 8'h11; wdata = 8'hB7; we = 1;
    #2 check("R6 ext we", {7'b0, ext_we}, 8'h01);
    check("R6 ext re low on plain write", {7'b0, ext_re}, 8'h00);
    @(negedge clk); idle();
    rd(8'h11, v); check("R6 ext write landed", v, 8'hB7);
    wr(8'h01, 8'h10);
    rd(8'h00, v); check("R6 indirect to ext", v, 8'h3C);
  endtask

  task automatic t_ro();
    logic [7:0] v;
    @(negedge clk); idle(); addr = 8'h20; wdata = 8'h00; we = 1;
    #2 check("R7 no we on read-only", {7'b0, ext_we}, 8'h00);
    @(negedge clk); idle();
    rd(8'h20, v); check("R7 read-only unchanged", v, 8'h77);
    bitop(8'h21, 1, 0, 3'd7);
    rd(8'h21, v); check("R7 bitop on read-only ignored", v, 8'h01);
  endtask

  task automatic t_bits();
    logic [7:0] v;
    wr(8'h50, 8'h00); bitop(8'h50, 1, 0, 3'd3);
    rd(8'h50, v); check("R8 set bit3", v, 8'h08);
    bitop(8'h50, 1, 0, 3'd0);
    rd(8'h50, v); check("R8 set bit0 keeps bit3", v, 8'h09);
    wr(8'h51, 8'hFF); bitop(8'h51, 0, 1, 3'd7);
    rd(8'h51, v); check("R9 clear bit7", v, 8'h7F);
    wr(8'h61, 8'hFF); bitop(8'h61, 1, 1, 3'd4);
    rd(8'h61, v); check("R9 clear beats set", v, 8'hEF);
    wr(8'h60, 8'h00);
    @(negedge clk); idle(); addr = 8'h60; wdata = 8'hF0; we = 1; bset = 1; bidx = 3'd1;
    @(negedge clk); idle();
    rd(8'h60, v); check("R9 bitop beats write", v, 8'h02);
    wr(8'h62, 8'h00); wr(8'h01, 8'h62); bitop(8'h00, 1, 0, 3'd2);
    rd(8'h62, v); check("R8 bit set via ptr0", v, 8'h04);
    @(negedge clk); idle(); addr = 8'h12; bset = 1; bidx = 3'd6;
    #2 check("R8 ext bitop data", ext_wdata, 8'h4F);
    check("R8 ext bitop strobes", {6'b0, ext_re, ext_we}, 8'h03);
    @(negedge clk); idle();
    rd(8'h12, v); check("R8 ext bitop landed", v, 8'h4F);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ext_mem[i] = 8'h00;
    ext_mem[6'h10] = 8'h3C; ext_mem[6'h12] = 8'h0F;
    ext_mem[6'h20] = 8'h77; ext_mem[6'h21] = 8'h01; ext_mem[6'h30] = 8'h99;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram();
    t_ind0();
    t_ind1();
    t_null();
    t_rsv();
    t_ext();
    t_ro();
    t_bits();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule